// File: doc/BRIEF.md
# Duplicated Register File with Nibble-Parity Repair

This block is a register file held twice, once per redundant pipeline copy (A and B). Each copy holds 32 entries. An entry is a 40-bit word: 32 data bits and one even-parity bit for each 4-bit nibble. Each pipeline copy produces its own word, parity included, and the array stores it exactly as it arrives. That lets an upset in one copy be seen in that copy's parity. An entry is written only when both copies' write enables agree. Three combinational read ports (two operand ports and one destination port) return both copies' raw words together with per-nibble parity-error flags. No correction is applied on these read paths.

A repair request works on one entry and takes two cycles. The first edge captures both copies of the entry. At the second edge, for every nibble, the copy that fails parity is overwritten from the other copy. If both copies fail in the same nibble, the block reports it as uncorrectable and leaves that nibble alone. A per-entry valid bit is cleared by reset and set by the first accepted write. Parity flags and repair act only on valid entries.

Top module: `dmr_rf_top`

## Requirements
- R1: After reset, every read port returns all-zero words and all-zero parity flags for every entry, and `fix_done` and `fix_uncorr` are low.
- R2: When `wr_en_a` and `wr_en_b` are both high at a clock edge, entry `wr_addr` takes `wr_word_a` in copy A and `wr_word_b` in copy B. Word layout: bits 31:0 are data and bit 32+k is the parity of nibble k (bits 4k+3:4k). Reads show the stored words combinationally.
- R3: A write with only one of the two enables high changes neither copy of any entry and does not mark the entry valid.
- R4: Flag bit k of a port's `rd_perr_a`/`rd_perr_b` is 1 exactly when the addressed entry is valid and the XOR of nibble k and its parity bit is 1. Ports 0 and 1 are operand ports and port 2 is the destination port. Each port decodes its own address independently.
- R5: The parity flags of an entry that has never been written are zero whatever it holds.
- R6: A `fix_req` sampled at edge t makes `fix_done` high during the following cycle. The corrected words are written at edge t+1.
- R7: For each nibble of a valid entry: if copy A fails parity and copy B passes, A's nibble and parity bit are replaced by B's. If A passes, B's nibble and parity bit are replaced by A's.
- R8: If some nibble fails parity in both copies, `fix_uncorr` is high together with `fix_done`, and that nibble stays unchanged in both copies. The other nibbles are still repaired.
- R9: A repair of a never-written entry changes nothing, raises no `fix_uncorr`, and leaves the entry invalid.
- R10: If an accepted write hits the repaired entry at the request edge or at the write-back edge, the written words remain and the repair write-back is dropped.
- R11: Repair requests on consecutive cycles are each handled. A repair write-back and an accepted write to a different entry at the same edge both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_a | input | 1 | Write enable from pipeline copy A |
| wr_en_b | input | 1 | Write enable from pipeline copy B |
| wr_addr | input | 5 | Write entry |
| wr_word_a | input | 40 | Word for copy A (data plus nibble parity) |
| wr_word_b | input | 40 | Word for copy B (data plus nibble parity) |
| rd_addr | input | 15 | Read addresses, port p in bits 5p+4:5p |
| rd_word_a | output | 120 | Copy A words, port p in bits 40p+39:40p |
| rd_word_b | output | 120 | Copy B words, port p in bits 40p+39:40p |
| rd_perr_a | output | 24 | Copy A nibble parity flags, port p in bits 8p+7:8p |
| rd_perr_b | output | 24 | Copy B nibble parity flags, port p in bits 8p+7:8p |
| fix_req | input | 1 | Start a repair of entry `fix_addr` |
| fix_addr | input | 5 | Entry to repair |
| fix_done | output | 1 | Repair write-back cycle |
| fix_uncorr | output | 1 | A nibble failed parity in both copies |

## Verification
The checker assumes a synchronous reset held for at least one edge, and it assumes every read address is below the entry count. The bench drives only addresses 0 to 31, so every index stays in range. The bench applies every stimulus one time unit after a rising edge and compares on the falling edge. It injects upsets only through the write port, by flipping data or parity bits in one copy's word, so the assertions never see a word that the interface could not deliver.

// File: rtl/dmr_rf_pkg.sv
// Package: default sizes for the duplicated register file.
// Assumes DATA_W is a multiple of the nibble width.
package dmr_rf_pkg;
    localparam int RF_ENTRIES  = 32;
    localparam int RF_DATA_W   = 32;
    localparam int RF_NIB_W    = 4;
    localparam int RF_RD_PORTS = 3;
endpackage

// File: rtl/dmr_nib_check.sv
// Per-nibble even-parity checker for one stored word.
// Word layout: data in the low DATA_W bits, parity of nibble k at bit DATA_W+k.
// Flags are forced low when en is low (entry not yet valid).
module dmr_nib_check #(
    parameter int DATA_W = 32,
    parameter int NIB_W  = 4,
    localparam int NNIB  = DATA_W / NIB_W,
    localparam int WW    = DATA_W + NNIB
) (
    input  logic [WW-1:0]   word,
    input  logic            en,
    output logic [NNIB-1:0] perr
);
    for (genvar k = 0; k < NNIB; k++) begin : g_nib
        // flag nibble k when its data and parity bit disagree
        assign perr[k] = en & ((^word[k*NIB_W +: NIB_W]) ^ word[DATA_W+k]);
    end
endmodule

// File: rtl/dmr_rf_copy.sv
// One copy of the register file: flop array with a normal write port,
// a repair write port, RD_PORTS combinational read ports and one scan read.
// Assumes the caller never enables both writes to the same entry together
// (the top cancels the repair in that case); normal write wins regardless.
module dmr_rf_copy #(
    parameter int ENTRIES  = 32,
    parameter int WW       = 40,
    parameter int RD_PORTS = 3,
    localparam int AW      = $clog2(ENTRIES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [AW-1:0]          waddr,
    input  logic [WW-1:0]          wdata,
    input  logic                   fix_we,
    input  logic [AW-1:0]          fix_waddr,
    input  logic [WW-1:0]          fix_wdata,
    input  logic [RD_PORTS*AW-1:0] raddr,
    output logic [RD_PORTS*WW-1:0] rdata,
    input  logic [AW-1:0]          scan_addr,
    output logic [WW-1:0]          scan_data
);
    logic [WW-1:0] mem_q [ENTRIES];

    // storage update: reset clears, normal write has priority over repair
    always_ff @(posedge clk) begin
        for (int e = 0; e < ENTRIES; e++) begin
            if (!rst_n) begin
                mem_q[e] <= '0;
            end else if (we && waddr == AW'(e)) begin
                mem_q[e] <= wdata;
            end else if (fix_we && fix_waddr == AW'(e)) begin
                mem_q[e] <= fix_wdata;
            end
        end
    end

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        // combinational read of port p
        assign rdata[p*WW +: WW] = mem_q[raddr[p*AW +: AW]];
    end

    // read used by the repair capture stage
    assign scan_data = mem_q[scan_addr];
endmodule

// File: rtl/dmr_repair_unit.sv
// Combinational repair decision for one entry.
// Per nibble: A bad and B good -> A takes B; A good -> B takes A;
// both bad -> nibble kept in both copies and uncorr raised.
// Assumes perr inputs are already gated by entry validity.
module dmr_repair_unit #(
    parameter int DATA_W = 32,
    parameter int NIB_W  = 4,
    localparam int NNIB  = DATA_W / NIB_W,
    localparam int WW    = DATA_W + NNIB
) (
    input  logic [WW-1:0]   word_a,
    input  logic [WW-1:0]   word_b,
    input  logic [NNIB-1:0] perr_a,
    input  logic [NNIB-1:0] perr_b,
    output logic [WW-1:0]   fixed_a,
    output logic [WW-1:0]   fixed_b,
    output logic            uncorr
);
    logic [NNIB-1:0] both_bad;

    for (genvar k = 0; k < NNIB; k++) begin : g_nib
        logic take_b;
        logic take_a;
        // choose the overwrite direction for nibble k
        assign take_b      = perr_a[k] & ~perr_b[k];
        assign take_a      = ~perr_a[k];
        assign both_bad[k] = perr_a[k] & perr_b[k];
        assign fixed_a[k*NIB_W +: NIB_W] = take_b ? word_b[k*NIB_W +: NIB_W] : word_a[k*NIB_W +: NIB_W];
        assign fixed_a[DATA_W+k]         = take_b ? word_b[DATA_W+k] : word_a[DATA_W+k];
        assign fixed_b[k*NIB_W +: NIB_W] = take_a ? word_a[k*NIB_W +: NIB_W] : word_b[k*NIB_W +: NIB_W];
        assign fixed_b[DATA_W+k]         = take_a ? word_a[DATA_W+k] : word_b[DATA_W+k];
    end

    assign uncorr = |both_bad;
endmodule

// File: rtl/dmr_rf_top.sv
// Duplicated register file with per-nibble parity flags and a two-cycle
// repair. A write lands only when both copies' enables agree. A repair
// captures the entry at the request edge and writes the corrected copies
// at the next edge unless a write to that entry intervened.
// Assumes read and repair addresses are below ENTRIES.
module dmr_rf_top
    import dmr_rf_pkg::*;
#(
    parameter int ENTRIES  = RF_ENTRIES,
    parameter int DATA_W   = RF_DATA_W,
    parameter int NIB_W    = RF_NIB_W,
    parameter int RD_PORTS = RF_RD_PORTS,
    localparam int AW      = $clog2(ENTRIES),
    localparam int NNIB    = DATA_W / NIB_W,
    localparam int WW      = DATA_W + NNIB
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en_a,
    input  logic                     wr_en_b,
    input  logic [AW-1:0]            wr_addr,
    input  logic [WW-1:0]            wr_word_a,
    input  logic [WW-1:0]            wr_word_b,
    input  logic [RD_PORTS*AW-1:0]   rd_addr,
    output logic [RD_PORTS*WW-1:0]   rd_word_a,
    output logic [RD_PORTS*WW-1:0]   rd_word_b,
    output logic [RD_PORTS*NNIB-1:0] rd_perr_a,
    output logic [RD_PORTS*NNIB-1:0] rd_perr_b,
    input  logic                     fix_req,
    input  logic [AW-1:0]            fix_addr,
    output logic                     fix_done,
    output logic                     fix_uncorr
);
    logic                wr_both;
    logic [ENTRIES-1:0]  valid_q;
    logic [WW-1:0]       scan_a, scan_b;
    logic                st_vld_q, st_ent_vld_q, st_stale_q;
    logic [AW-1:0]       st_addr_q;
    logic [WW-1:0]       st_word_a_q, st_word_b_q;
    logic [NNIB-1:0]     st_perr_a, st_perr_b;
    logic [WW-1:0]       fixed_a, fixed_b;
    logic                st_uncorr;
    logic                cancel;
    logic                fix_we;

    assign wr_both = wr_en_a & wr_en_b;

    // valid tracking: cleared by reset, set by the first accepted write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_both) begin
            valid_q[wr_addr] <= 1'b1;
        end
    end

    dmr_rf_copy #(.ENTRIES(ENTRIES), .WW(WW), .RD_PORTS(RD_PORTS)) copy_a_i (
        .clk(clk), .rst_n(rst_n),
        .we(wr_both), .waddr(wr_addr), .wdata(wr_word_a),
        .fix_we(fix_we), .fix_waddr(st_addr_q), .fix_wdata(fixed_a),
        .raddr(rd_addr), .rdata(rd_word_a),
        .scan_addr(fix_addr), .scan_data(scan_a)
    );

    dmr_rf_copy #(.ENTRIES(ENTRIES), .WW(WW), .RD_PORTS(RD_PORTS)) copy_b_i (
        .clk(clk), .rst_n(rst_n),
        .we(wr_both), .waddr(wr_addr), .wdata(wr_word_b),
        .fix_we(fix_we), .fix_waddr(st_addr_q), .fix_wdata(fixed_b),
        .raddr(rd_addr), .rdata(rd_word_b),
        .scan_addr(fix_addr), .scan_data(scan_b)
    );

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_port
        logic port_vld;
        assign port_vld = valid_q[rd_addr[p*AW +: AW]];
        dmr_nib_check #(.DATA_W(DATA_W), .NIB_W(NIB_W)) chk_a_i (
            .word(rd_word_a[p*WW +: WW]), .en(port_vld), .perr(rd_perr_a[p*NNIB +: NNIB])
        );
        dmr_nib_check #(.DATA_W(DATA_W), .NIB_W(NIB_W)) chk_b_i (
            .word(rd_word_b[p*WW +: WW]), .en(port_vld), .perr(rd_perr_b[p*NNIB +: NNIB])
        );
    end

    // repair capture stage: hold the entry read at the request edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_vld_q     <= 1'b0;
            st_ent_vld_q <= 1'b0;
            st_stale_q   <= 1'b0;
            st_addr_q    <= '0;
            st_word_a_q  <= '0;
            st_word_b_q  <= '0;
        end else begin
            st_vld_q <= fix_req;
            if (fix_req) begin
                st_addr_q    <= fix_addr;
                st_word_a_q  <= scan_a;
                st_word_b_q  <= scan_b;
                st_ent_vld_q <= valid_q[fix_addr];
                st_stale_q   <= wr_both && (wr_addr == fix_addr);
            end
        end
    end

    dmr_nib_check #(.DATA_W(DATA_W), .NIB_W(NIB_W)) st_chk_a_i (
        .word(st_word_a_q), .en(st_ent_vld_q), .perr(st_perr_a)
    );
    dmr_nib_check #(.DATA_W(DATA_W), .NIB_W(NIB_W)) st_chk_b_i (
        .word(st_word_b_q), .en(st_ent_vld_q), .perr(st_perr_b)
    );

    dmr_repair_unit #(.DATA_W(DATA_W), .NIB_W(NIB_W)) rep_i (
        .word_a(st_word_a_q), .word_b(st_word_b_q),
        .perr_a(st_perr_a), .perr_b(st_perr_b),
        .fixed_a(fixed_a), .fixed_b(fixed_b), .uncorr(st_uncorr)
    );

    // drop the write-back when fresh write data reached the entry
    assign cancel     = st_stale_q | (wr_both && (wr_addr == st_addr_q));
    assign fix_we     = st_vld_q & st_ent_vld_q & ~cancel;
    assign fix_done   = st_vld_q;
    assign fix_uncorr = st_vld_q & st_uncorr;
endmodule

// File: rtl/dmr_rf_chk.sv
// Checker for dmr_rf_top, attached by bind. Assumes synchronous reset
// and read addresses below ENTRIES.
module dmr_rf_chk #(
    parameter int ENTRIES  = 32,
    parameter int NNIB     = 8,
    parameter int RD_PORTS = 3,
    localparam int AW      = $clog2(ENTRIES)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_en_a,
    input logic                     wr_en_b,
    input logic                     fix_req,
    input logic                     fix_done,
    input logic                     fix_uncorr,
    input logic [ENTRIES-1:0]       valid_q,
    input logic [RD_PORTS*AW-1:0]   rd_addr,
    input logic [RD_PORTS*NNIB-1:0] rd_perr_a,
    input logic [RD_PORTS*NNIB-1:0] rd_perr_b
);
    // R3: a new valid bit needs both enables at the previous edge
    assert_valid_needs_both_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((valid_q & ~$past(valid_q)) != '0) |-> $past(wr_en_a && wr_en_b));

    // R9: valid bits never clear outside reset (repair leaves them alone)
    assert_valid_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((valid_q & $past(valid_q)) == $past(valid_q)));

    // R6: done follows a request by exactly one cycle
    assert_done_after_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fix_req |=> fix_done);
    assert_no_done_without_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !fix_req |=> !fix_done);

    // R8: uncorrectable is reported only in a write-back cycle
    assert_uncorr_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fix_uncorr |-> fix_done);

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_port
        // R5: no parity flags on an unwritten entry
        assert_unwritten_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !valid_q[rd_addr[p*AW +: AW]] |->
                (rd_perr_a[p*NNIB +: NNIB] == '0 && rd_perr_b[p*NNIB +: NNIB] == '0));
    end
endmodule

bind dmr_rf_top dmr_rf_chk #(.ENTRIES(ENTRIES), .NNIB(NNIB), .RD_PORTS(RD_PORTS)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en_a(wr_en_a), .wr_en_b(wr_en_b),
    .fix_req(fix_req), .fix_done(fix_done), .fix_uncorr(fix_uncorr),
    .valid_q(valid_q), .rd_addr(rd_addr),
    .rd_perr_a(rd_perr_a), .rd_perr_b(rd_perr_b)
);

// File: tb/dmr_rf_top_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks push expected items, a falling-edge
// monitor pops and compares them against the ports.
module dmr_rf_top_tb_top;
    localparam int AW = 5, WW = 40, NN = 8, NP = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en_a = 1'b0, wr_en_b = 1'b0;
    logic [AW-1:0]    wr_addr = '0;
    logic [WW-1:0]    wr_word_a = '0, wr_word_b = '0;
    logic [NP*AW-1:0] rd_addr = '0;
    logic [NP*WW-1:0] rd_word_a, rd_word_b;
    logic [NP*NN-1:0] rd_perr_a, rd_perr_b;
    logic             fix_req = 1'b0;
    logic [AW-1:0]    fix_addr = '0;
    logic             fix_done, fix_uncorr;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    dmr_rf_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en_a(wr_en_a), .wr_en_b(wr_en_b), .wr_addr(wr_addr),
        .wr_word_a(wr_word_a), .wr_word_b(wr_word_b),
        .rd_addr(rd_addr), .rd_word_a(rd_word_a), .rd_word_b(rd_word_b),
        .rd_perr_a(rd_perr_a), .rd_perr_b(rd_perr_b),
        .fix_req(fix_req), .fix_addr(fix_addr),
        .fix_done(fix_done), .fix_uncorr(fix_uncorr)
    );

    typedef struct {
        int          kind;  // 0 read port, 1 repair status
        int          port;
        logic [39:0] ea, eb;
        logic [7:0]  pa, pb;
        logic        done, unc;
        string       tag;
    } item_t;
    item_t sb_q[$];

    // bench model of the two copies and the valid bits
    logic [39:0] ma [32];
    logic [39:0] mb [32];
    bit          mv [32];

    function automatic logic [39:0] mkword(input logic [31:0] d);
        logic [7:0] p;
        for (int k = 0; k < 8; k++) p[k] = ^d[4*k +: 4];
        return {p, d};
    endfunction

    function automatic logic [7:0] flags(input logic [39:0] w, input bit v);
        logic [7:0] f;
        for (int k = 0; k < 8; k++) f[k] = v & ((^w[4*k +: 4]) ^ w[32+k]);
        return f;
    endfunction

    // per-nibble repair rule applied to the model
    function automatic void model_fix(input int e);
        logic [7:0] fa, fb;
        if (!mv[e]) return;
        fa = flags(ma[e], 1'b1);
        fb = flags(mb[e], 1'b1);
        for (int k = 0; k < 8; k++) begin
            if (fa[k] && fb[k]) continue;
            if (fa[k]) begin
                ma[e][4*k +: 4] = mb[e][4*k +: 4];
                ma[e][32+k]     = mb[e][32+k];
            end else begin
                mb[e][4*k +: 4] = ma[e][4*k +: 4];
                mb[e][32+k]     = ma[e][32+k];
            end
        end
    endfunction

    // scoreboard monitor: compare all queued items away from the rising edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            total++;
            if (it.kind == 0) begin
                logic [39:0] aa, ab;
                logic [7:0]  fa, fb;
                aa = rd_word_a[it.port*WW +: WW];
                ab = rd_word_b[it.port*WW +: WW];
                fa = rd_perr_a[it.port*NN +: NN];
                fb = rd_perr_b[it.port*NN +: NN];
                if (aa !== it.ea || ab !== it.eb || fa !== it.pa || fb !== it.pb) begin
                    bad++;
                    $display("FAIL %s port%0d: got a=%h b=%h fa=%h fb=%h exp a=%h b=%h fa=%h fb=%h",
                             it.tag, it.port, aa, ab, fa, fb, it.ea, it.eb, it.pa, it.pb);
                end
            end else begin
                if (fix_done !== it.done || fix_uncorr !== it.unc) begin
                    bad++;
                    $display("FAIL %s: got done=%b unc=%b exp done=%b unc=%b",
                             it.tag, fix_done, fix_uncorr, it.done, it.unc);
                end
            end
        end
    end

    // one clock of stimulus; inputs change 1 ns after the rising edge
    task automatic step(input bit wa, input bit wb, input int wad,
                        input logic [39:0] da, input logic [39:0] db,
                        input bit rq, input int fad);
        wr_en_a = wa; wr_en_b = wb; wr_addr = AW'(wad);
        wr_word_a = da; wr_word_b = db;
        fix_req = rq; fix_addr = AW'(fad);
        @(posedge clk); #1;
        wr_en_a = 1'b0; wr_en_b = 1'b0; fix_req = 1'b0;
        if (wa && wb) begin
            ma[wad] = da; mb[wad] = db; mv[wad] = 1;
        end
    endtask

    task automatic idle();
        step(0, 0, 0, '0, '0, 0, 0);
    endtask

    task automatic wr(input int e, input logic [39:0] da, input logic [39:0] db);
        step(1, 1, e, da, db, 0, 0);
    endtask

    task automatic chk_stat(input logic d, input logic u, input string tag);
        item_t it;
        it.kind = 1; it.port = 0; it.ea = '0; it.eb = '0; it.pa = '0; it.pb = '0;
        it.done = d; it.unc = u; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic chk_read(input int p, input int e, input string tag);
        item_t it;
        rd_addr[p*AW +: AW] = AW'(e);
        it.kind = 0; it.port = p; it.ea = ma[e]; it.eb = mb[e];
        it.pa = flags(ma[e], mv[e]); it.pb = flags(mb[e], mv[e]);
        it.done = 0; it.unc = 0; it.tag = tag;
        sb_q.push_back(it);
        @(posedge clk); #1;
    endtask

    // full repair: request, status check, write-back edge, model update
    task automatic do_repair(input int e, input logic u, input string tag);
        step(0, 0, 0, '0, '0, 1, e);
        chk_stat(1, u, tag);
        idle();
        model_fix(e);
    endtask

    initial begin
        for (int e = 0; e < 32; e++) begin
            ma[e] = '0; mb[e] = '0; mv[e] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset contents and idle status
        chk_stat(0, 0, "R1 idle status");
        chk_read(0, 0, "R1 reset entry 0");
        chk_read(2, 31, "R1 reset entry 31");

        // R2 and R4: clean write seen on all three ports
        wr(3, mkword(32'hDEAD_BEEF), mkword(32'hDEAD_BEEF));
        chk_read(0, 3, "R2 port0");
        chk_read(1, 3, "R2 port1");
        chk_read(2, 3, "R4 port2 clean");

        // R3: single-enable writes are ignored
        step(1, 0, 3, mkword(32'h1111_1111), mkword(32'h1111_1111), 0, 0);
        chk_read(0, 3, "R3 only A enable");
        step(0, 1, 25, mkword(32'h5) ^ 40'h01_0000_0000, mkword(32'h5), 0, 0);
        chk_read(1, 25, "R3 only B enable unwritten");

        // R4: injected parity upset in copy A nibble 2, seen by two ports
        wr(7, mkword(32'h1234_5678) ^ (40'h1 << 34), mkword(32'h1234_5678));
        chk_read(0, 7, "R4 A nibble2 flag");
        chk_read(2, 7, "R4 A nibble2 flag dest port");
        // R7: A bad -> A repaired from B
        do_repair(7, 1'b0, "R6 repair 7 status");
        chk_read(1, 7, "R7 A fixed from B");

        // R7: B bad in nibbles 0 and 5 -> B repaired from A
        wr(9, mkword(32'hCAFE_F00D), mkword(32'hCAFE_F00D) ^ 40'h0000_100000 ^ 40'h1);
        chk_read(0, 9, "R4 B flags");
        do_repair(9, 1'b0, "R6 repair 9 status");
        chk_read(0, 9, "R7 B fixed from A");

        // R8: nibble 1 bad in both copies, nibble 3 bad in A only
        wr(10, mkword(32'hA5A5_A5A5) ^ 40'h10 ^ 40'h1000,
               mkword(32'hA5A5_A5A5) ^ (40'h1 << 33));
        do_repair(10, 1'b1, "R8 uncorrectable status");
        chk_read(2, 10, "R8 both-bad nibble kept, other fixed");

        // R7: both parities good but data differ -> B takes A
        wr(12, mkword(32'h0003_0000 ^ 32'h7777_7777), mkword(32'h7777_7777));
        do_repair(12, 1'b0, "R7 mismatch status");
        chk_read(0, 12, "R7 good A overwrites B");

        // R9: repair of a never-written entry
        do_repair(20, 1'b0, "R9 unwritten status");
        chk_read(2, 20, "R9 unwritten unchanged");
        chk_read(0, 25, "R9 still unflagged");

        // R10: write at the request edge wins
        wr(14, mkword(32'h0BAD_0000) ^ 40'h1, mkword(32'h0BAD_0000));
        step(1, 1, 14, mkword(32'h600D_0001), mkword(32'h600D_0001), 1, 14);
        chk_stat(1, 0, "R10 stale request status");
        idle();
        chk_read(0, 14, "R10 write at request edge kept");

        // R10: write at the write-back edge wins
        wr(15, mkword(32'h0BAD_1111) ^ 40'h2, mkword(32'h0BAD_1111));
        step(0, 0, 0, '0, '0, 1, 15);
        chk_stat(1, 0, "R10 request status");
        wr(15, mkword(32'h600D_2222), mkword(32'h600D_2222) ^ (40'h1 << 39));
        chk_read(1, 15, "R10 write at writeback edge kept");

        // R11: back-to-back repairs with a write to another entry
        wr(16, mkword(32'h1616_1616) ^ (40'h1 << 24), mkword(32'h1616_1616));
        wr(17, mkword(32'h1717_1717), mkword(32'h1717_1717) ^ (40'h1 << 39));
        step(0, 0, 0, '0, '0, 1, 16);
        chk_stat(1, 0, "R11 first repair status");
        step(1, 1, 18, mkword(32'h1818_1818), mkword(32'h1818_1818), 1, 17);
        model_fix(16);
        chk_stat(1, 0, "R11 second repair status");
        idle();
        model_fix(17);
        chk_stat(0, 0, "R6 done drops after repair");
        chk_read(0, 16, "R11 entry 16 fixed");
        chk_read(1, 17, "R11 entry 17 fixed");
        chk_read(2, 18, "R11 parallel write landed");

        idle();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // watchdog: a hung run counts as a failed check
    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule